// File: doc/BRIEF.md
# Pulse-Swallow Programmable Channel Divider

This block is the feedback divider of a channel-selecting frequency synthesizer, written as a clock-enable design. Each cycle in which `in_en` is high stands for one cycle of the fast input. A dual-modulus prescaler divides the enable stream by N or N+1. A program counter counts P prescaler periods per output period. A swallow counter keeps the prescaler at N+1 for the first S of those periods, and then releases the modulus line. One output period therefore spans P·N + S enables.

A small channel number picks S as `S_BASE + ch_sel`. It changes only the swallow count, so neighbouring channels differ by exactly one input cycle. The channel number is sampled only at the start of an output period, so no period mixes two ratios. With the default parameters (N = 8, P = 26, S_BASE = 12, 3-bit channel) the eight channels give division ratios 220 through 227. When N is a power of two of at least 4, the prescaler is built as a divide-by-2/3 stage followed by divide-by-two stages. For any other N it is a plain modulo counter.

Top module: `chan_divider`

## Requirements
- R1: `rst` is synchronous and active high. While it is held, `out_pulse` is 0 and `mod_ctl` is 1. After release, the first `out_pulse` falls on the M-th enable, where M is the ratio of the channel sampled during reset.
- R2: Successive `out_pulse` assertions are exactly M = P·N + S enables apart, with S = S_BASE + `ch_sel`. With the defaults, `ch_sel` 0 gives 220 and each further code adds one, up to 227 for code 7.
- R3: `mod_ctl` is high during exactly the first S·(N+1) enables of every output period and low for the remaining (P−S)·N enables. It changes only right after a prescaler period ends.
- R4: `out_pulse` is high only in a clock cycle where `in_en` is high. It lasts one clock and marks the last enable of the period.
- R5: `ch_sel` is sampled only while `rst` is high and in the clock cycle of an `out_pulse`. A change at any other time has no effect on the period under way and takes effect in the next one.
- R6: Cycles with `in_en` low advance no counter. The spacing measured in enables is the same for continuous, alternating and irregular enable patterns.
- R7: One prescaler period lasts N+1 enables while `mod_ctl` is high and N enables while it is low. This holds for the divide-by-2/3 structure and for the generic counter alike, for any N of at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| in_en | input | 1 | Input-cycle enable; each high cycle is one input cycle |
| ch_sel | input | CH_W | Channel number; S = S_BASE + ch_sel |
| out_pulse | output | 1 | One-clock pulse on the last enable of each output period |
| mod_ctl | output | 1 | Prescaler modulus line; 1 selects N+1, 0 selects N |

## Verification
The bench builds two instances side by side. The first uses the defaults (N = 8, P = 26, S_BASE = 12), which brings in the divide-by-2/3 prescaler structure and the ratios 220 to 227. The second uses N = 6, P = 9, S_BASE = 1 with a swallow limit of 8. That choice selects the generic modulo prescaler and reaches the smallest swallow count, S = 1, as well as the largest count the hardware allows, S = P−1. Together they cover both generate branches, every channel code of each instance, several enable patterns, and a channel change in the middle of a period.

// File: rtl/chdiv_pkg.sv
package chdiv_pkg;

   typedef enum logic {
      PRE_STAGED  = 1'b0,
      PRE_COUNTER = 1'b1
   } pre_style_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic pre_style_e pick_style(input int unsigned n);
      return (is_pow2(n) && n >= 4) ? PRE_STAGED : PRE_COUNTER;
   endfunction

   function automatic int unsigned div_ratio(input int unsigned p,
                                             input int unsigned n,
                                             input int unsigned s);
      return p * n + s;
   endfunction

endpackage

// File: rtl/chdiv_prescaler.sv
module chdiv_prescaler
   import chdiv_pkg::*;
#(
   parameter int unsigned N     = 8,
   parameter pre_style_e  STYLE = PRE_STAGED
) (
   input  logic clk,
   input  logic rst,
   input  logic in_en,
   input  logic mod_hi,
   output logic tick
);

   generate
      if (STYLE == PRE_STAGED) begin : g_staged
         localparam int unsigned K  = $clog2(N);
         localparam int unsigned HW = K - 1;

         logic [1:0]    first_q;
         logic [HW-1:0] upper_q;
         logic          upper_full;
         logic          stretch;
         logic          first_carry;

         assign upper_full  = &upper_q;
         assign stretch     = mod_hi & upper_full;
         assign first_carry = in_en & (first_q == (stretch ? 2'd2 : 2'd1));
         assign tick        = first_carry & upper_full;

         always_ff @(posedge clk) begin
            if (rst) begin
               first_q <= 2'd0;
               upper_q <= '0;
            end else if (in_en) begin
               if (first_carry) begin
                  first_q <= 2'd0;
                  upper_q <= upper_q + HW'(1);
               end else begin
                  first_q <= first_q + 2'd1;
               end
            end
         end
      end else begin : g_counter
         localparam int unsigned CW = $clog2(N + 1);

         logic [CW-1:0] cnt_q;
         logic [CW-1:0] last_val;

         assign last_val = mod_hi ? CW'(N) : CW'(N - 1);
         assign tick     = in_en & (cnt_q == last_val);

         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
            end else if (in_en) begin
               cnt_q <= tick ? '0 : cnt_q + CW'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/chdiv_prog_cnt.sv
module chdiv_prog_cnt #(
   parameter int unsigned P = 26
) (
   input  logic clk,
   input  logic rst,
   input  logic pre_tick,
   output logic at_last
);

   localparam int unsigned PW = (P > 1) ? $clog2(P) : 1;

   logic [PW-1:0] cnt_q;

   assign at_last = (cnt_q == PW'(P - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (pre_tick) begin
         cnt_q <= at_last ? '0 : cnt_q + PW'(1);
      end
   end

endmodule

// File: rtl/chdiv_swallow.sv
module chdiv_swallow #(
   parameter int unsigned SW_W = 5
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            restart,
   input  logic            pre_tick,
   input  logic [SW_W-1:0] s_lim,
   output logic            mod_hi
);

   logic [SW_W-1:0] cnt_q;
   logic            mod_q;
   logic            reached;

   assign reached = (cnt_q == s_lim - SW_W'(1));
   assign mod_hi  = mod_q;

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         cnt_q <= '0;
         mod_q <= 1'b1;
      end else if (pre_tick && mod_q) begin
         cnt_q <= cnt_q + SW_W'(1);
         if (reached) begin
            mod_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/chan_divider.sv
module chan_divider
   import chdiv_pkg::*;
#(
   parameter int unsigned N        = 8,
   parameter int unsigned P        = 26,
   parameter int unsigned S_BASE   = 12,
   parameter int unsigned CH_W     = 3,
   parameter int unsigned S_HW_MAX = 24
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_en,
   input  logic [CH_W-1:0] ch_sel,
   output logic            out_pulse,
   output logic            mod_ctl
);

   localparam int unsigned S_MAX      = S_BASE + (1 << CH_W) - 1;
   localparam int unsigned SW_W       = $clog2(S_HW_MAX + 1);
   localparam pre_style_e  PRE_STYLE  = pick_style(N);

   generate
      if (N < 2) begin : g_bad_n
         $error("chan_divider: N must be at least 2");
      end
      if (S_BASE < 1) begin : g_bad_base
         $error("chan_divider: S_BASE must be at least 1");
      end
      if (S_MAX > S_HW_MAX) begin : g_bad_span
         $error("chan_divider: channel span exceeds swallow hardware limit");
      end
      if (S_HW_MAX >= P) begin : g_bad_prog
         $error("chan_divider: swallow limit must stay below P");
      end
   endgenerate

   logic            pre_tick;
   logic            prog_last;
   logic [SW_W-1:0] s_act_q;

   assign out_pulse = pre_tick & prog_last;

   always_ff @(posedge clk) begin
      if (rst || out_pulse) begin
         s_act_q <= SW_W'(S_BASE) + SW_W'(ch_sel);
      end
   end

   chdiv_prescaler #(
      .N     (N),
      .STYLE (PRE_STYLE)
   ) u_pre (
      .clk    (clk),
      .rst    (rst),
      .in_en  (in_en),
      .mod_hi (mod_ctl),
      .tick   (pre_tick)
   );

   chdiv_prog_cnt #(
      .P (P)
   ) u_prog (
      .clk      (clk),
      .rst      (rst),
      .pre_tick (pre_tick),
      .at_last  (prog_last)
   );

   chdiv_swallow #(
      .SW_W (SW_W)
   ) u_swal (
      .clk      (clk),
      .rst      (rst),
      .restart  (out_pulse),
      .pre_tick (pre_tick),
      .s_lim    (s_act_q),
      .mod_hi   (mod_ctl)
   );

endmodule

// File: rtl/chdiv_chk.sv
module chdiv_chk #(
   parameter int unsigned N      = 8,
   parameter int unsigned P      = 26,
   parameter int unsigned S_BASE = 12,
   parameter int unsigned CH_W   = 3
) (
   input logic            clk,
   input logic            rst,
   input logic            in_en,
   input logic [CH_W-1:0] ch_sel,
   input logic            out_pulse,
   input logic            mod_ctl,
   input logic            pre_tick
);

   localparam int unsigned MAXM = P * (N + 1);
   localparam int unsigned CW   = $clog2(MAXM + 1);
   localparam int unsigned PCW  = $clog2(N + 2);

   logic [CW-1:0]  per_cnt;
   logic [CW-1:0]  exp_s;
   logic [PCW-1:0] pre_cnt;
   logic           rst_d;

   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst) begin
         per_cnt <= '0;
         pre_cnt <= '0;
         exp_s   <= CW'(S_BASE) + CW'(ch_sel);
      end else if (in_en) begin
         per_cnt <= out_pulse ? '0 : per_cnt + CW'(1);
         pre_cnt <= pre_tick ? '0 : pre_cnt + PCW'(1);
         if (out_pulse) begin
            exp_s <= CW'(S_BASE) + CW'(ch_sel);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst_d && !rst) begin
         a_reset_state_r1: assert (mod_ctl && !out_pulse)
            else $error("R1: state after reset wrong");
      end
   end

   p_period_r2: assert property (@(posedge clk) disable iff (rst)
      out_pulse |-> (per_cnt + CW'(1) == CW'(P * N) + exp_s));

   p_mod_window_r3: assert property (@(posedge clk) disable iff (rst)
      in_en |-> (mod_ctl == (per_cnt < exp_s * CW'(N + 1))));

   p_mod_edge_r3: assert property (@(posedge clk) disable iff (rst)
      !$stable(mod_ctl) |-> $past(pre_tick));

   p_pulse_en_r4: assert property (@(posedge clk) disable iff (rst)
      out_pulse |-> in_en);

   p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
      out_pulse |=> !out_pulse);

   p_pre_ratio_r7: assert property (@(posedge clk) disable iff (rst)
      pre_tick |-> (pre_cnt + PCW'(1) == (mod_ctl ? PCW'(N + 1) : PCW'(N))));

endmodule

bind chan_divider chdiv_chk #(
   .N      (N),
   .P      (P),
   .S_BASE (S_BASE),
   .CH_W   (CH_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_en     (in_en),
   .ch_sel    (ch_sel),
   .out_pulse (out_pulse),
   .mod_ctl   (mod_ctl),
   .pre_tick  (pre_tick)
);

// File: tb/chan_divider_tb.sv
`timescale 1ns/1ps
module chan_divider_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_en = 1'b0;
   logic [2:0] ch_sel = 3'd0;
   logic       pulse_a, mod_a, pulse_b, mod_b;

   int   n_tests = 0;
   int   n_fail  = 0;
   int   en_mode = 0;
   logic [7:0] lfsr = 8'hA5;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   chan_divider u_dut (
      .clk(clk), .rst(rst), .in_en(in_en), .ch_sel(ch_sel),
      .out_pulse(pulse_a), .mod_ctl(mod_a)
   );

   chan_divider #(.N(6), .P(9), .S_BASE(1), .CH_W(3), .S_HW_MAX(8)) u_dut_b (
      .clk(clk), .rst(rst), .in_en(in_en), .ch_sel(ch_sel),
      .out_pulse(pulse_b), .mod_ctl(mod_b)
   );

   // enable pattern generator
   initial begin
      forever begin
         @(posedge clk);
         #1;
         case (en_mode)
            0: in_en = 1'b1;
            1: in_en = ~in_en;
            default: begin
               lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
               in_en = lfsr[0] | lfsr[2];
            end
         endcase
      end
   end

   // period monitors (sample away from the active edge)
   int en_a = 0, mc_a = 0, gap_a = 0, mgap_a = 0, np_a = 0, bad_a = 0, dbl_a = 0;
   int en_b = 0, mc_b = 0, gap_b = 0, mgap_b = 0, np_b = 0, bad_b = 0, dbl_b = 0;
   logic prev_a = 1'b0, prev_b = 1'b0;

   always @(negedge clk) begin
      if (rst) begin
         en_a = 0; mc_a = 0; prev_a = 1'b0;
      end else begin
         if (pulse_a && !in_en) bad_a++;
         if (pulse_a && prev_a) dbl_a++;
         prev_a = pulse_a;
         if (in_en) begin
            en_a++;
            if (mod_a) mc_a++;
            if (pulse_a) begin
               gap_a = en_a; mgap_a = mc_a; np_a++;
               en_a = 0; mc_a = 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst) begin
         en_b = 0; mc_b = 0; prev_b = 1'b0;
      end else begin
         if (pulse_b && !in_en) bad_b++;
         if (pulse_b && prev_b) dbl_b++;
         prev_b = pulse_b;
         if (in_en) begin
            en_b++;
            if (mod_b) mc_b++;
            if (pulse_b) begin
               gap_b = en_b; mgap_b = mc_b; np_b++;
               en_b = 0; mc_b = 0;
            end
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("[TB] FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_a();
      int n0 = np_a;
      while (np_a == n0) @(posedge clk);
   endtask

   task automatic wait_b();
      int n0 = np_b;
      while (np_b == n0) @(posedge clk);
   endtask

   task automatic set_ch(input int c);
      #1;
      ch_sel = 3'(c);
   endtask

   // R1: reset state and first period
   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1 pulse in reset", int'(pulse_a), 0);
      check("R1 mod in reset", int'(mod_a), 1);
      check("R1 mod in reset B", int'(mod_b), 1);
      @(posedge clk); #1;
      rst = 1'b0;
      wait_b();
      check("R1 first period B", gap_b, 55);
      wait_a();
      check("R1 first period A", gap_a, 220);
      check("R1 one pulse A", np_a, 1);
   endtask

   // R2, R3: every channel of the default build
   task automatic t_channels_a();
      for (int c = 0; c < 8; c++) begin
         set_ch(c);
         wait_a();
         wait_a();
         check($sformatf("R2 ch%0d period", c), gap_a, 220 + c);
         check($sformatf("R3 ch%0d mod span", c), mgap_a, (12 + c) * 9);
      end
   endtask

   // R7, R2: every channel of the generic-prescaler build
   task automatic t_channels_b();
      for (int c = 0; c < 8; c++) begin
         set_ch(c);
         wait_b();
         wait_b();
         check($sformatf("R2 B ch%0d period", c), gap_b, 55 + c);
         check($sformatf("R7 B ch%0d mod span", c), mgap_b, (1 + c) * 7);
      end
   endtask

   // R6: enable gaps do not change spacing
   task automatic t_gaps();
      en_mode = 1;
      set_ch(5);
      wait_a();
      wait_a();
      check("R6 alternating period", gap_a, 225);
      check("R6 alternating mod span", mgap_a, 17 * 9);
      en_mode = 2;
      @(posedge clk);
      set_ch(3);
      wait_a();
      wait_a();
      check("R6 irregular period", gap_a, 223);
      check("R6 irregular mod span", mgap_a, 15 * 9);
      en_mode = 0;
   endtask

   // R5: channel change mid-period affects only the next period
   task automatic t_midchange();
      set_ch(2);
      wait_a();
      wait_a();
      repeat (40) @(posedge clk);
      set_ch(6);
      wait_a();
      check("R5 current period kept", gap_a, 222);
      wait_a();
      check("R5 next period uses new", gap_a, 226);
   endtask

   // R4: pulse shape
   task automatic t_pulse_shape();
      check("R4 pulse without enable A", bad_a, 0);
      check("R4 pulse wider than one clock A", dbl_a, 0);
      check("R4 pulse without enable B", bad_b, 0);
      check("R4 pulse wider than one clock B", dbl_b, 0);
   endtask

   initial begin
      t_reset();
      t_channels_a();
      t_channels_b();
      t_gaps();
      t_midchange();
      t_pulse_shape();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("[TB] FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule